// File: doc/BRIEF.md
# Transmitter Slew-Rate Calibration Sequencer

This block is a state machine that tunes the high-speed transmitter edge rate once, at power-up. A `start_i` pulse launches the sequence. First a ring oscillator is turned on and given time to settle. Then a free-running clock is enabled, a frequency meter is loaded with its measurement window of 1024 cycles, and the meter is started. The sequencer polls the meter's valid flag at a coarse interval. It captures the count either when the flag is seen or when a timeout expires. After the capture, the sequencer stops the meter and then the free-running clock.

From the captured count it computes a 3-bit slew-control code. The code is the product of reference frequency (MHz), coefficient and window length, divided by the count, then divided by a scale of 1000 with round-to-nearest. Both divisions share one restoring divider. The sequencer then writes the code, turns the oscillator off and pulses `done_o`. Software-style overrides arrive as plain inputs: a nonzero forced code bypasses the whole measurement, and the reference frequency and coefficient are sampled at start.

Time-based waits are expressed in microseconds and turned into clock cycles through the `CLK_MHZ` parameter.

Top module: `srcal_seq`

## Requirements
- R1: When `start_i` is seen with `force_code_i` nonzero, the oscillator, free-run clock and meter enables stay low, `code_o` takes the forced value, and `done_o` pulses.
- R2: The free-run clock enable rises no earlier than SETTLE_US microseconds (SETTLE_US×CLK_MHZ cycles) after the oscillator enable rises, and is only high while the oscillator enable is high.
- R3: `cycle_cnt_o` holds METER_CYCLES (1024 by default) before the meter enable rises and for as long as it stays high; the meter enable rises after the free-run clock enable.
- R4: While measuring, `meter_valid_i` is sampled once every POLL_US microseconds. The count is captured at the first poll that sees valid, or at the poll where TIMEOUT_US microseconds have elapsed even if valid never arrived.
- R5: After capture the meter enable falls before the free-run clock enable falls. The oscillator enable falls only after `code_o` holds its final value, and all three enables are low when `done_o` is high.
- R6: For a nonzero captured count, `code_o` = floor((floor(ref×coef×1024/count) + 500) / 1000), saturated to 7.
- R7: A captured count of zero yields `code_o` = 3.
- R8: `done_o` is high for exactly one cycle per sequence, and a `start_i` pulse arriving while a sequence runs has no effect on it or on the final code.
- R9: After reset all enables, `done_o`, `code_o` and `cycle_cnt_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; ignored while a sequence runs |
| force_code_i | input | 3 | Forced slew code; nonzero bypasses calibration |
| ref_mhz_i | input | 8 | Reference frequency in MHz (typically 26) |
| coef_i | input | 8 | Calibration coefficient (typically 17) |
| osc_en_o | output | 1 | Ring oscillator enable |
| frck_en_o | output | 1 | Free-running clock enable |
| meter_en_o | output | 1 | Frequency meter enable |
| cycle_cnt_o | output | 24 | Meter measurement window in cycles |
| meter_valid_i | input | 1 | Meter result valid |
| meter_count_i | input | 24 | Meter result count |
| code_o | output | 3 | Slew-control code |
| done_o | output | 1 | One-cycle sequence-complete pulse |

## Verification
The assertions assume that `meter_valid_i` and `meter_count_i` are only meaningful while the meter enable is high, and that `start_i`, `force_code_i`, `ref_mhz_i` and `coef_i` change only at points where the sequencer is idle or where their effect is meant to be ignored. The bench models the meter as a responder. It raises valid a chosen number of cycles after the meter enable rises, or never, and drops it when the enable falls. Random reference, coefficient, count and delay values are drawn within the port widths and within a delay range shorter than the timeout. Directed cases cover the zero count, saturation, an exact rounding midpoint, a timeout and a start pulse while busy.

// File: rtl/srcal_pkg.sv
package srcal_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_OSC_SETTLE,
      ST_FRCK_ON,
      ST_LOAD_WIN,
      ST_METER_ON,
      ST_POLL,
      ST_METER_OFF,
      ST_FRCK_OFF,
      ST_DIV_RATIO,
      ST_DIV_SCALE,
      ST_WRITE,
      ST_OSC_OFF,
      ST_FINISH
   } srcal_state_e;

endpackage

// File: rtl/srcal_ustick.sv
module srcal_ustick #(
   parameter int CLK_MHZ = 26,
   parameter int US_W    = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear_i,
   output logic            tick_o,
   output logic [US_W-1:0] elapsed_o
);
   localparam int CYC_W = (CLK_MHZ > 1) ? $clog2(CLK_MHZ) : 1;
   localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CLK_MHZ - 1);
   localparam logic [US_W-1:0]  US_MAX   = '1;

   logic [CYC_W-1:0] cyc_q;

   generate
      if (CLK_MHZ < 1) begin : g_bad_clk
         $error("srcal_ustick: CLK_MHZ must be at least 1");
      end
   endgenerate

   assign tick_o = !clear_i && (cyc_q == CYC_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_q     <= '0;
         elapsed_o <= '0;
      end else if (clear_i) begin
         cyc_q     <= '0;
         elapsed_o <= '0;
      end else if (cyc_q == CYC_LAST) begin
         cyc_q <= '0;
         if (elapsed_o != US_MAX) elapsed_o <= elapsed_o + 1'b1;
      end else begin
         cyc_q <= cyc_q + 1'b1;
      end
   end
endmodule

// File: rtl/srcal_rdiv.sv
module srcal_rdiv #(
   parameter int W = 28
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go_i,
   input  logic [W-1:0] dividend_i,
   input  logic [W-1:0] divisor_i,
   output logic         done_o,
   output logic [W-1:0] quot_o
);
   localparam int CW = $clog2(W + 1);

   logic [W:0]    rem_q;
   logic [W-1:0]  dsr_q;
   logic [CW-1:0] left_q;
   logic [W:0]    trial;

   generate
      if (W < 2) begin : g_bad_w
         $error("srcal_rdiv: W must be at least 2");
      end
   endgenerate

   assign trial = {rem_q[W-1:0], quot_o[W-1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         dsr_q  <= '0;
         quot_o <= '0;
         left_q <= '0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (go_i) begin
            rem_q  <= '0;
            dsr_q  <= divisor_i;
            quot_o <= dividend_i;
            left_q <= CW'(W);
         end else if (left_q != '0) begin
            if (trial >= {1'b0, dsr_q}) begin
               rem_q  <= trial - {1'b0, dsr_q};
               quot_o <= {quot_o[W-2:0], 1'b1};
            end else begin
               rem_q  <= trial;
               quot_o <= {quot_o[W-2:0], 1'b0};
            end
            left_q <= left_q - 1'b1;
            if (left_q == CW'(1)) done_o <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/srcal_seq.sv
module srcal_seq
   import srcal_pkg::*;
#(
   parameter int CLK_MHZ      = 26,
   parameter int SETTLE_US    = 1,
   parameter int POLL_US      = 10,
   parameter int TIMEOUT_US   = 200,
   parameter int REF_W        = 8,
   parameter int COEF_W       = 8,
   parameter int CNT_W        = 24,
   parameter int CODE_W       = 3,
   parameter int METER_CYCLES = 1024,
   parameter int SCALE        = 1000,
   parameter int DEFAULT_CODE = 3,
   parameter bit SATURATE     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CODE_W-1:0] force_code_i,
   input  logic [REF_W-1:0]  ref_mhz_i,
   input  logic [COEF_W-1:0] coef_i,
   output logic              osc_en_o,
   output logic              frck_en_o,
   output logic              meter_en_o,
   output logic [CNT_W-1:0]  cycle_cnt_o,
   input  logic              meter_valid_i,
   input  logic [CNT_W-1:0]  meter_count_i,
   output logic [CODE_W-1:0] code_o,
   output logic              done_o
);
   localparam int WIN_W   = $clog2(METER_CYCLES + 1);
   localparam int DIV_W   = REF_W + COEF_W + WIN_W + 1;
   localparam int US_W    = $clog2(TIMEOUT_US + SETTLE_US + 2);
   localparam int PC_W    = $clog2(POLL_US + 1);
   localparam int HALF    = SCALE / 2;
   localparam int CODE_MX = (1 << CODE_W) - 1;

   generate
      if (CNT_W > DIV_W) begin : g_bad_cnt
         $error("srcal_seq: CNT_W must not exceed the divider width");
      end
      if (METER_CYCLES >= (1 << CNT_W) || METER_CYCLES < 1) begin : g_bad_win
         $error("srcal_seq: METER_CYCLES does not fit cycle_cnt_o");
      end
      if (DEFAULT_CODE > CODE_MX) begin : g_bad_def
         $error("srcal_seq: DEFAULT_CODE does not fit CODE_W");
      end
      if (POLL_US < 1 || TIMEOUT_US < POLL_US || SETTLE_US < 1) begin : g_bad_time
         $error("srcal_seq: timing parameters inconsistent");
      end
      if (SCALE < 2) begin : g_bad_scale
         $error("srcal_seq: SCALE must be at least 2");
      end
   endgenerate

   srcal_state_e      state_q;
   logic [REF_W-1:0]  ref_q;
   logic [COEF_W-1:0] coef_q;
   logic [CNT_W-1:0]  cap_q;
   logic [CODE_W-1:0] result_q;
   logic [PC_W-1:0]   poll_q;
   logic [DIV_W-1:0]  div_a_q;
   logic [DIV_W-1:0]  div_b_q;
   logic              div_go_q;
   logic              div_done;
   logic [DIV_W-1:0]  div_quot;
   logic              tmr_clr;
   logic              us_tick;
   logic [US_W-1:0]   us_elapsed;
   logic              poll_evt;
   logic              time_up;
   logic [DIV_W-1:0]  product;
   logic [CODE_W-1:0] code_fit;

   assign tmr_clr  = (state_q == ST_IDLE) || (state_q == ST_METER_ON);
   assign poll_evt = us_tick && (poll_q == PC_W'(POLL_US - 1));
   assign time_up  = (us_elapsed >= US_W'(TIMEOUT_US - 1));
   assign product  = DIV_W'(ref_q) * DIV_W'(coef_q) * DIV_W'(METER_CYCLES);

   generate
      if (SATURATE) begin : g_sat
         assign code_fit = (div_quot > DIV_W'(CODE_MX)) ? CODE_W'(CODE_MX)
                                                         : div_quot[CODE_W-1:0];
      end else begin : g_wrap
         assign code_fit = div_quot[CODE_W-1:0];
      end
   endgenerate

   srcal_ustick #(
      .CLK_MHZ (CLK_MHZ),
      .US_W    (US_W)
   ) u_tick (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (tmr_clr),
      .tick_o    (us_tick),
      .elapsed_o (us_elapsed)
   );

   srcal_rdiv #(
      .W (DIV_W)
   ) u_div (
      .clk        (clk),
      .rst_n      (rst_n),
      .go_i       (div_go_q),
      .dividend_i (div_a_q),
      .divisor_i  (div_b_q),
      .done_o     (div_done),
      .quot_o     (div_quot)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         ref_q       <= '0;
         coef_q      <= '0;
         cap_q       <= '0;
         result_q    <= '0;
         poll_q      <= '0;
         div_a_q     <= '0;
         div_b_q     <= '0;
         div_go_q    <= 1'b0;
         osc_en_o    <= 1'b0;
         frck_en_o   <= 1'b0;
         meter_en_o  <= 1'b0;
         cycle_cnt_o <= '0;
         code_o      <= '0;
         done_o      <= 1'b0;
      end else begin
         done_o   <= 1'b0;
         div_go_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  if (force_code_i != '0) begin
                     code_o  <= force_code_i;
                     state_q <= ST_FINISH;
                  end else begin
                     ref_q    <= ref_mhz_i;
                     coef_q   <= coef_i;
                     osc_en_o <= 1'b1;
                     state_q  <= ST_OSC_SETTLE;
                  end
               end
            end
            ST_OSC_SETTLE: begin
               if (us_elapsed >= US_W'(SETTLE_US)) state_q <= ST_FRCK_ON;
            end
            ST_FRCK_ON: begin
               frck_en_o <= 1'b1;
               state_q   <= ST_LOAD_WIN;
            end
            ST_LOAD_WIN: begin
               cycle_cnt_o <= CNT_W'(METER_CYCLES);
               state_q     <= ST_METER_ON;
            end
            ST_METER_ON: begin
               meter_en_o <= 1'b1;
               poll_q     <= '0;
               state_q    <= ST_POLL;
            end
            ST_POLL: begin
               if (us_tick) begin
                  poll_q <= poll_evt ? '0 : poll_q + 1'b1;
               end
               if (poll_evt && (meter_valid_i || time_up)) begin
                  cap_q   <= meter_count_i;
                  state_q <= ST_METER_OFF;
               end
            end
            ST_METER_OFF: begin
               meter_en_o <= 1'b0;
               state_q    <= ST_FRCK_OFF;
            end
            ST_FRCK_OFF: begin
               frck_en_o <= 1'b0;
               if (cap_q == '0) begin
                  result_q <= CODE_W'(DEFAULT_CODE);
                  state_q  <= ST_WRITE;
               end else begin
                  div_a_q  <= product;
                  div_b_q  <= DIV_W'(cap_q);
                  div_go_q <= 1'b1;
                  state_q  <= ST_DIV_RATIO;
               end
            end
            ST_DIV_RATIO: begin
               if (div_done) begin
                  div_a_q  <= div_quot + DIV_W'(HALF);
                  div_b_q  <= DIV_W'(SCALE);
                  div_go_q <= 1'b1;
                  state_q  <= ST_DIV_SCALE;
               end
            end
            ST_DIV_SCALE: begin
               if (div_done) begin
                  result_q <= code_fit;
                  state_q  <= ST_WRITE;
               end
            end
            ST_WRITE: begin
               code_o  <= result_q;
               state_q <= ST_OSC_OFF;
            end
            ST_OSC_OFF: begin
               osc_en_o <= 1'b0;
               state_q  <= ST_FINISH;
            end
            ST_FINISH: begin
               done_o  <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/srcal_seq_chk.sv
module srcal_seq_chk #(
   parameter int CLK_MHZ      = 26,
   parameter int SETTLE_US    = 1,
   parameter int CNT_W        = 24,
   parameter int CODE_W       = 3,
   parameter int METER_CYCLES = 1024
) (
   input logic              clk,
   input logic              rst_n,
   input logic              osc_en_o,
   input logic              frck_en_o,
   input logic              meter_en_o,
   input logic [CNT_W-1:0]  cycle_cnt_o,
   input logic [CODE_W-1:0] code_o,
   input logic              done_o
);
   localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;
   localparam int RW         = $clog2(SETTLE_CYC + 2);
   localparam logic [RW-1:0] RUN_MAX = RW'(SETTLE_CYC + 1);

   logic [RW-1:0] osc_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  osc_run <= '0;
      else if (!osc_en_o)          osc_run <= '0;
      else if (osc_run != RUN_MAX) osc_run <= osc_run + 1'b1;
   end

   AST_FRCK_NEEDS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
      frck_en_o |-> osc_en_o); // R2
   AST_SETTLE_TIME: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frck_en_o) |-> (osc_run >= RW'(SETTLE_CYC))); // R2
   AST_METER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      meter_en_o |-> (cycle_cnt_o == CNT_W'(METER_CYCLES))); // R3
   AST_METER_NEEDS_FRCK: assert property (@(posedge clk) disable iff (!rst_n)
      meter_en_o |-> frck_en_o); // R5
   AST_DONE_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!osc_en_o && !frck_en_o && !meter_en_o)); // R5
   AST_CODE_HELD_MEAS: assert property (@(posedge clk) disable iff (!rst_n)
      frck_en_o |-> $stable(code_o)); // R6
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R8
endmodule

bind srcal_seq srcal_seq_chk #(
   .CLK_MHZ      (CLK_MHZ),
   .SETTLE_US    (SETTLE_US),
   .CNT_W        (CNT_W),
   .CODE_W       (CODE_W),
   .METER_CYCLES (METER_CYCLES)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .osc_en_o    (osc_en_o),
   .frck_en_o   (frck_en_o),
   .meter_en_o  (meter_en_o),
   .cycle_cnt_o (cycle_cnt_o),
   .code_o      (code_o),
   .done_o      (done_o)
);

// File: tb/srcal_seq_tb.sv
module srcal_seq_tb;
   localparam int CLK_PERIOD  = 10;
   localparam int CLK_MHZ     = 2;
   localparam int SETTLE_US   = 1;
   localparam int POLL_US     = 10;
   localparam int TIMEOUT_US  = 200;
   localparam int SETTLE_CYC  = CLK_MHZ * SETTLE_US;
   localparam int POLL_CYC    = CLK_MHZ * POLL_US;
   localparam int TIMEOUT_CYC = CLK_MHZ * TIMEOUT_US;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [2:0]  force_code_i = '0;
   logic [7:0]  ref_mhz_i = 8'd26;
   logic [7:0]  coef_i = 8'd17;
   logic        meter_valid_i = 1'b0;
   logic [23:0] meter_count_i = '0;
   logic        osc_en_o, frck_en_o, meter_en_o, done_o;
   logic [23:0] cycle_cnt_o;
   logic [2:0]  code_o;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   srcal_seq #(
      .CLK_MHZ    (CLK_MHZ),
      .SETTLE_US  (SETTLE_US),
      .POLL_US    (POLL_US),
      .TIMEOUT_US (TIMEOUT_US)
   ) u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start_i),
      .force_code_i  (force_code_i),
      .ref_mhz_i     (ref_mhz_i),
      .coef_i        (coef_i),
      .osc_en_o      (osc_en_o),
      .frck_en_o     (frck_en_o),
      .meter_en_o    (meter_en_o),
      .cycle_cnt_o   (cycle_cnt_o),
      .meter_valid_i (meter_valid_i),
      .meter_count_i (meter_count_i),
      .code_o        (code_o),
      .done_o        (done_o)
   );

   function automatic int exp_code(int r, int c, int cnt);
      longint q;
      if (cnt == 0) return 3;
      q = (longint'(r) * longint'(c) * 1024) / cnt;
      q = (q + 500) / 1000;
      return (q > 7) ? 7 : int'(q);
   endfunction

   task automatic check(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic run_cal(input int frc, input int r, input int c, input int cnt,
                          input int vdel, input bit poke, input string tag);
      int cyc = 0;
      int t_or = -1, t_fr = -1, t_mr = -1, t_mf = -1, t_ff = -1, t_of = -1;
      int dones = 0, meter_hi = 0, tail = -1, win_at_mr = -1, code_at_of = -1;
      int exp, lat;
      bit po = 0, pf = 0, pm = 0;
      exp = (frc != 0) ? frc : exp_code(r, c, cnt);
      @(negedge clk);
      start_i = 1'b1; force_code_i = 3'(frc); ref_mhz_i = 8'(r); coef_i = 8'(c);
      meter_count_i = 24'(cnt);
      @(negedge clk);
      start_i = 1'b0;
      while (cyc < 3000 && tail != 0) begin
         cyc++;
         if (osc_en_o && !po) t_or = cyc;
         if (!osc_en_o && po) begin t_of = cyc; code_at_of = int'(code_o); end
         if (frck_en_o && !pf) t_fr = cyc;
         if (!frck_en_o && pf) t_ff = cyc;
         if (meter_en_o && !pm) begin t_mr = cyc; win_at_mr = int'(cycle_cnt_o); end
         if (!meter_en_o && pm) t_mf = cyc;
         po = osc_en_o; pf = frck_en_o; pm = meter_en_o;
         if (done_o) dones++;
         if (done_o && tail < 0) tail = 5;
         else if (tail > 0) tail--;
         meter_hi = meter_en_o ? meter_hi + 1 : 0;
         meter_valid_i = (vdel >= 0) && (meter_hi > vdel);
         if (poke && cyc == 10) begin start_i = 1'b1; force_code_i = 3'd6; end
         else if (poke && cyc == 11) begin start_i = 1'b0; force_code_i = 3'd0; end
         @(negedge clk);
      end
      meter_valid_i = 1'b0;
      check(dones == 1, "R8", {tag, " done pulses"}, dones, 1);
      check(int'(code_o) == exp, (frc != 0) ? "R1" : (cnt == 0 ? "R7" : "R6"),
            {tag, " code"}, int'(code_o), exp);
      if (frc != 0) begin
         check(t_or == -1 && t_fr == -1 && t_mr == -1, "R1", {tag, " no osc"}, t_or, -1);
      end else begin
         check(t_fr - t_or >= SETTLE_CYC, "R2", {tag, " settle"}, t_fr - t_or, SETTLE_CYC);
         check(t_mr > t_fr && win_at_mr == 1024, "R3", {tag, " window"}, win_at_mr, 1024);
         lat = t_mf - t_mr;
         if (vdel >= 0)
            check(lat >= vdel && lat <= vdel + POLL_CYC + 6, "R4", {tag, " poll latency"},
                  lat, vdel);
         else
            check(lat >= TIMEOUT_CYC && lat <= TIMEOUT_CYC + POLL_CYC + 6, "R4",
                  {tag, " timeout"}, lat, TIMEOUT_CYC);
         check(t_mf > 0 && t_ff > t_mf, "R5", {tag, " meter before frck"}, t_ff, t_mf + 1);
         check(t_of > t_ff && code_at_of == exp, "R5", {tag, " code before osc off"},
               code_at_of, exp);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = 32'h5EC0_1A7E;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      // R9 reset state
      check(!osc_en_o && !frck_en_o && !meter_en_o && !done_o, "R9", "enables at reset",
            {osc_en_o, frck_en_o, meter_en_o, done_o}, 0);
      check(code_o == 0 && cycle_cnt_o == 0, "R9", "code/window at reset", int'(code_o), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      run_cal(5, 26, 17, 150, 10, 1'b0, "R1 forced");
      run_cal(0, 26, 17, 150, 30, 1'b0, "nominal");
      run_cal(0, 26, 17, 60, 5, 1'b0, "R6 saturate");
      run_cal(0, 26, 17, 0, 12, 1'b0, "R7 zero");
      run_cal(0, 26, 17, 300, -1, 1'b0, "R4 timeout");
      run_cal(0, 26, 17, 100, 40, 1'b1, "R8 busy start");
      run_cal(0, 60, 25, 1024, 0, 1'b0, "R6 midpoint");
      run_cal(0, 26, 17, 4000, 90, 1'b0, "R6 small");
      for (int i = 0; i < 8; i++) begin
         run_cal(0, 10 + int'($urandom % 51), 5 + int'($urandom % 36),
                 1 + int'($urandom % 4000), int'($urandom % 151), 1'b0, "random");
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule